// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Tagged Receive Queue

This block recovers characters from an asynchronous serial input line. The line is first passed through a short chain of synchronizing flops. The block then runs on a sampling strobe that pulses sixteen times per bit period. A falling edge on an idle line arms the start-bit check. The line is looked at again half a bit later to reject glitches. Data bits are then captured at the middle of each bit cell, least significant bit first.

Each completed character goes into a small first-in first-out queue, together with three flags: parity error, framing error and break. The head entry and its flags are always visible at the outputs, along with the queue occupancy. A consumer removes the head entry by pulsing the pop input.

A character that arrives while the queue is full is dropped, and a one-cycle overrun pulse is raised. Character length, parity enable and parity mode come in on static configuration inputs. They must not change while a character is being received.

Top module: `serial_rx_core`

## Requirements
- R1: The input line passes through a two-flop synchronizer. A low level seen on a strobe while idle is checked again eight strobes later. If the line is high at that check, the start is dropped and no queue entry is produced.
- R2: `cfg_len` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits arrive least significant first, one bit cell being 16 strobes. Data bits above the selected length read as zero, and each character produces exactly one queue entry.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_mode` selects the expected value: code 0 is even (the bit equals the XOR of the data bits), code 1 is odd (its inverse), code 2 is a constant 1 and code 3 is a constant 0. When `cfg_par_en` is 0, no parity bit is taken.
- R4: The parity error flag of an entry is 1 when the received parity bit differs from the value R3 expects, and 0 otherwise.
- R5: The framing error flag is 1 when the first stop bit is sampled low. Any further stop bits are not checked.
- R6: A break is a character whose data bits, parity bit (if enabled) and first stop bit are all sampled low. It produces one entry with data 0, the break flag set, the framing flag set and the parity flag clear. No new start is accepted until the line has been seen high again.
- R7: The queue holds DEPTH entries (default 16) in arrival order. `level` gives the number of entries held, and `rd_data` with its flags shows the oldest entry.
- R8: A character that completes while the queue is full is discarded, and the queue contents stay unchanged. `overrun` pulses high for one cycle, one clock after that character completes.
- R9: `rd_valid` is 1 exactly when the queue is not empty. A pop while the queue is empty has no effect.
- R10: After reset, `level` is 0, `rd_valid` is 0 and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sampling strobe, 16 pulses per bit |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data bit count code (0..3 for 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | Parity mode: even, odd, constant 1, constant 0 |
| pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break flag |
| rd_valid | output | 1 | Queue not empty |
| level | output | $clog2(DEPTH)+1 | Number of entries held |
| overrun | output | 1 | One-cycle pulse on a dropped character |

## Verification
The hardest cases to reach from the ports are those at the edges of the queue and the line timing. One is an overrun, which needs the queue filled exactly to capacity with no pops before one more character arrives. The other is a glitch short enough to fail the half-bit recheck. The stimulus covers both with directed sequences: seventeen back-to-back characters with pop held low, and a low pulse of six strobes on an idle line. Random characters of mixed length, parity mode, corrupted parity and low stop bits then exercise the flag logic. Some of these all-zero frames fall into the break rule.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef struct packed {
      logic       brk;
      logic       ferr;
      logic       perr;
      logic [7:0] data;
   } rx_entry_t;

   localparam int ENTRY_W = $bits(rx_entry_t);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_WAIT_HI
   } rx_state_t;

   localparam logic [1:0] PAR_EVEN  = 2'd0;
   localparam logic [1:0] PAR_ODD   = 2'd1;
   localparam logic [1:0] PAR_ONE   = 2'd2;
   localparam logic [1:0] PAR_ZERO  = 2'd3;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rx_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
   import serial_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      rxd,
   input  logic [1:0] cfg_len,
   input  logic      cfg_par_en,
   input  logic [1:0] cfg_par_mode,
   output logic      push,
   output rx_entry_t push_word
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(OVS - 1);

   rx_state_t  state;
   logic [CW-1:0] cnt;
   logic [2:0] bitn;
   logic [7:0] shreg;
   logic       parbit;
   logic [2:0] last_bit;
   logic       par_exp;
   logic       brk_c;
   logic       perr_c;

   assign last_bit = {1'b0, cfg_len} + 3'd4;

   always_comb begin
      unique case (cfg_par_mode)
         PAR_EVEN: par_exp = ^shreg;
         PAR_ODD:  par_exp = ~(^shreg);
         PAR_ONE:  par_exp = 1'b1;
         default:  par_exp = 1'b0;
      endcase
      brk_c  = (shreg == 8'd0) && !rxd && (!cfg_par_en || !parbit);
      perr_c = cfg_par_en && (parbit != par_exp) && !brk_c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         bitn      <= '0;
         shreg     <= '0;
         parbit    <= 1'b0;
         push      <= 1'b0;
         push_word <= '0;
      end else begin
         push <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (tick && !rxd) begin
                  state <= ST_START;
                  cnt   <= '0;
               end
            end
            ST_START: begin
               if (tick) begin
                  if (cnt == CNT_HALF) begin
                     cnt   <= '0;
                     bitn  <= '0;
                     shreg <= '0;
                     state <= rxd ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (tick) begin
                  if (cnt == CNT_FULL) begin
                     cnt         <= '0;
                     shreg[bitn] <= rxd;
                     if (bitn == last_bit) state <= cfg_par_en ? ST_PAR : ST_STOP;
                     else                  bitn  <= bitn + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_PAR: begin
               if (tick) begin
                  if (cnt == CNT_FULL) begin
                     cnt    <= '0;
                     parbit <= rxd;
                     state  <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_STOP: begin
               if (tick) begin
                  if (cnt == CNT_FULL) begin
                     cnt            <= '0;
                     push           <= 1'b1;
                     push_word.data <= brk_c ? 8'd0 : shreg;
                     push_word.brk  <= brk_c;
                     push_word.ferr <= !rxd;
                     push_word.perr <= perr_c;
                     parbit         <= 1'b0;
                     state          <= brk_c ? ST_WAIT_HI : ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               if (rxd) state <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic [AW:0]  level,
   output logic         full,
   output logic         empty
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad
         $error("rx_fifo DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wptr, rptr;
   logic         wr_ok, rd_ok;

   assign level = wptr - rptr;
   assign full  = (level == (AW+1)'(DEPTH));
   assign empty = (level == '0);
   assign wr_ok = wr && !full;
   assign rd_ok = rd && !empty;
   assign rdata = mem[rptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (wr_ok) wptr <= wptr + 1'b1;
         if (rd_ok) rptr <= rptr + 1'b1;
      end
   end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
   import serial_rx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   localparam int LW         = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick16,
   input  logic          rxd,
   input  logic [1:0]    cfg_len,
   input  logic          cfg_par_en,
   input  logic [1:0]    cfg_par_mode,
   input  logic          pop,
   output logic [7:0]    rd_data,
   output logic          rd_perr,
   output logic          rd_ferr,
   output logic          rd_brk,
   output logic          rd_valid,
   output logic [LW-1:0] level,
   output logic          overrun
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
   endgenerate

   logic      rxd_s;
   logic      rx_push;
   rx_entry_t rx_word;
   rx_entry_t head;
   logic      q_full, q_empty;

   rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
   );

   rx_framer #(.OVS(OVS)) u_framer (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd_s),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
      .push(rx_push), .push_word(rx_word)
   );

   rx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr(rx_push), .wdata(rx_word),
      .rd(pop), .rdata(head), .level(level), .full(q_full), .empty(q_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) overrun <= 1'b0;
      else        overrun <= rx_push && q_full;
   end

   assign rd_data  = head.data;
   assign rd_perr  = head.perr;
   assign rd_ferr  = head.ferr;
   assign rd_brk   = head.brk;
   assign rd_valid = !q_empty;
endmodule

// File: rtl/serial_rx_checks.sv
module serial_rx_checks #(
   parameter int DEPTH = 16,
   localparam int LW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pop,
   input logic          push,
   input logic [LW-1:0] level,
   input logic          rd_valid,
   input logic [7:0]    rd_data,
   input logic          rd_brk,
   input logic          rd_ferr,
   input logic          overrun
);
   AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH)); // R7

   AST_VALID_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == (level != '0)); // R9

   AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && rd_valid && !push) |=> level == $past(level) - 1'b1); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && level == LW'(DEPTH) && !pop) |=> (level == LW'(DEPTH)) && overrun); // R8

   AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_brk) |-> (rd_data == 8'd0) && rd_ferr); // R6

   AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !push); // R2
endmodule

bind serial_rx_core serial_rx_checks #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .pop(pop), .push(rx_push), .level(level),
   .rd_valid(rd_valid), .rd_data(rd_data), .rd_brk(rd_brk),
   .rd_ferr(rd_ferr), .overrun(overrun)
);

// File: tb/serial_rx_core_test.sv
`timescale 1ns/1ps
module serial_rx_core_test;
   localparam int DEPTH  = 16;
   localparam int TDIV   = 4;
   localparam int BITCLK = 16 * TDIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick16 = 1'b0;
   logic rxd = 1'b1;
   logic [1:0] cfg_len = 2'd3;
   logic cfg_par_en = 1'b0;
   logic [1:0] cfg_par_mode = 2'd0;
   logic pop = 1'b0;
   logic [7:0] rd_data;
   logic rd_perr, rd_ferr, rd_brk, rd_valid;
   logic [4:0] level;
   logic overrun;

   int checks = 0;
   int errors = 0;
   int ovr_seen = 0;
   int tcnt = 0;
   logic [10:0] exp_q[$];

   serial_rx_core #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
      .pop(pop), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
      .rd_brk(rd_brk), .rd_valid(rd_valid), .level(level), .overrun(overrun)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      tcnt   <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      tick16 <= (tcnt == TDIV - 1);
      if (overrun) ovr_seen <= ovr_seen + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit par_of(input logic [7:0] d, input logic [1:0] pm);
      case (pm)
         2'd0: return ^d;
         2'd1: return ~(^d);
         2'd2: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic line(input bit v, input int clocks);
      rxd = v;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input logic [1:0] lc, input bit pe,
                       input logic [1:0] pm, input bit flip, input bit bad_stop);
      int nb = int'(lc) + 5;
      logic [7:0] dm = d & ((8'd1 << nb) - 8'd1);
      bit p = par_of(dm, pm) ^ flip;
      bit brk;
      cfg_len = lc; cfg_par_en = pe; cfg_par_mode = pm;
      line(1'b0, BITCLK);
      for (int i = 0; i < nb; i++) line(dm[i], BITCLK);
      if (pe) line(p, BITCLK);
      line(!bad_stop, BITCLK);
      line(1'b1, 2 * BITCLK);
      brk = (dm == 8'd0) && (!pe || !p) && bad_stop;
      if (exp_q.size() < DEPTH) begin
         if (brk) exp_q.push_back({3'b110, 8'd0});
         else     exp_q.push_back({1'b0, bad_stop, pe && flip, dm});
      end
   endtask

   task automatic drain();
      chk(int'(level) == exp_q.size(), "R7", "level before drain", level, exp_q.size());
      while (rd_valid) begin
         logic [10:0] got = {rd_brk, rd_ferr, rd_perr, rd_data};
         logic [10:0] want;
         string tag;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected entry", got, 0);
         end else begin
            want = exp_q.pop_front();
            tag = want[10] ? "R6" : want[9] ? "R5" : want[8] ? "R4" : "R2";
            chk(got == want, tag, "entry {brk,ferr,perr,data}", got, want);
         end
         @(negedge clk) pop = 1'b1;
         @(negedge clk) pop = 1'b0;
      end
      chk(exp_q.size() == 0, "R7", "entries missing", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      fork
         begin
            repeat (190000) @(posedge clk);
            chk(1'b0, "WATCHDOG", "timeout", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      join_none
      void'($urandom(32'h1234_5eed));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(level == 0, "R10", "reset level", level, 0);
      chk(rd_valid == 0, "R10", "reset rd_valid", rd_valid, 0);
      chk(overrun == 0, "R10", "reset overrun", overrun, 0);

      // R9: pop on empty queue
      pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
      chk(level == 0, "R9", "pop on empty", level, 0);
      line(1'b1, BITCLK);

      // R1: short glitch is rejected
      line(1'b0, 6 * TDIV);
      line(1'b1, 3 * BITCLK);
      chk(level == 0, "R1", "false start level", level, 0);

      // directed formats: R2 R3 R4 R5 R6
      send(8'hA5, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
      send(8'h3C, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0);
      send(8'h3C, 2'd3, 1'b1, 2'd1, 1'b1, 1'b0);
      send(8'h55, 2'd1, 1'b1, 2'd2, 1'b0, 1'b0);
      send(8'h7F, 2'd2, 1'b1, 2'd3, 1'b1, 1'b0);
      send(8'h81, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1);
      // R6: break held well past a character, then a normal frame
      cfg_len = 2'd3; cfg_par_en = 1'b0;
      line(1'b0, 14 * BITCLK);
      line(1'b1, 2 * BITCLK);
      exp_q.push_back({3'b110, 8'd0});
      send(8'hC3, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0);
      chk(level == 8, "R6", "single break entry", level, 8);
      drain();

      // R8: overrun with the queue full
      ovr_seen = 0;
      for (int i = 0; i < DEPTH + 1; i++)
         send(8'(i * 7 + 1), 2'd3, 1'b0, 2'd0, 1'b0, 1'b0);
      chk(level == DEPTH, "R8", "level after overrun", level, DEPTH);
      chk(ovr_seen == 1, "R8", "overrun pulses", ovr_seen, 1);
      drain();

      // random mixture
      for (int n = 0; n < 40; n++) begin
         logic [7:0] d = 8'($urandom);
         if ($urandom_range(0, 7) == 0) d = 8'd0;
         send(d, 2'($urandom), 1'($urandom), 2'($urandom),
              $urandom_range(0, 4) == 0, $urandom_range(0, 5) == 0);
         if (exp_q.size() >= 8) drain();
      end
      drain();
      chk(ovr_seen == 1, "R8", "no spurious overrun", ovr_seen, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule